// File: doc/BRIEF.md
# Descriptor Chain Fetch Unit

This unit walks a linked chain of transfer descriptors kept in memory for a single DMA channel. Each descriptor is four 32-bit words placed at consecutive word addresses: a control word at byte offset 0x0, a source address at 0x4, a destination address at 0x8 and a pointer to the following descriptor at 0xC. When the channel engine asks for a load, the unit reads the four words one after another through a simple request/valid read port. It then updates the channel's working configuration in a single cycle.

The working configuration has four direction and select flags, a 12-bit total size, the source and destination addresses, the address of the descriptor just consumed and the pointer to the next one. A "more follows" flag tells the engine whether another descriptor should be fetched once the current transfer completes. When the channel does not use descriptors, a load request only clears that flag. The pointer to the head of the chain is set through a dedicated strobe.

Top module: `desc_chain_fetch`

## Requirements
- R1: During and after reset, every configuration output, `load_done` and `rd_req` are zero.
- R2: A `load_req` accepted while idle with `use_desc` high raises `rd_req` and reads the addresses pointer+0x0, +0x4, +0x8 and +0xC in that order. Only one read is outstanding at a time, and `rd_addr` is held until `rd_valid` is seen.
- R3: From the control word, bit 19 goes to `inc_src`, bit 18 to `inc_dst`, bit 17 to `sel_src`, bit 16 to `sel_dst`, and bits 11:0 go to `total_size`.
- R4: The word at offset 0x4 becomes `src_addr` and the word at offset 0x8 becomes `dst_addr`.
- R5: `cur_desc` takes the address the descriptor was read from, and `desc_ptr` takes the word at offset 0xC.
- R6: `more_follows` is set to the inverse of bit 20 of the control word. Bit 20 set means end of list.
- R7: `load_done` is high for one cycle, in the cycle after the fourth word is accepted. No configuration output changes before that cycle, so all of them update together.
- R8: A `load_req` accepted while idle with `use_desc` low issues no read and clears `more_follows`. It pulses `load_done` in the next cycle and leaves every other output unchanged.
- R9: A `load_req` that arrives while a fetch is in progress is ignored.
- R10: `head_set` while idle loads `desc_ptr` from `head_ptr`. If it comes in the same cycle as an accepted `load_req`, the fetch starts from `head_ptr`. `head_set` during a fetch is ignored.
- R11: Memory latency may be any number of cycles. A `rd_valid` seen while `rd_req` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_req | input | 1 | Request to load the next descriptor |
| use_desc | input | 1 | Channel works from a descriptor chain |
| head_set | input | 1 | Strobe to load the chain head pointer |
| head_ptr | input | AW | Chain head address |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | AW | Memory read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| inc_src | output | 1 | Source address increments |
| inc_dst | output | 1 | Destination address increments |
| sel_src | output | 1 | Source interface select |
| sel_dst | output | 1 | Destination interface select |
| total_size | output | SZW | Transfer size from the descriptor |
| src_addr | output | AW | Source address |
| dst_addr | output | AW | Destination address |
| cur_desc | output | AW | Address of the descriptor last loaded |
| desc_ptr | output | AW | Address of the next descriptor |
| more_follows | output | 1 | Chain continues after the current entry |
| load_done | output | 1 | One-cycle pulse when a load completes |

## Verification
Two functions can fall in the same cycle. The first is a head-pointer write together with a load request. The bench drives both in one idle cycle and expects the fetch to read from the new head; it judges this by the read addresses and by `cur_desc` after completion. The second is a new load request held high through the completion pulse. The bench expects the next fetch to start from the pointer just committed, with no idle gap. A behavioural model steps alongside the design under random-free variable memory latency and stray valid pulses, and every output is compared on every cycle.

// File: rtl/desc_chain_pkg.sv
// Shared constants and types for the descriptor chain fetch unit.
// Assumes descriptors are four consecutive 32-bit words.
package desc_chain_pkg;
    localparam int CTL_EOL     = 20;
    localparam int CTL_INC_SRC = 19;
    localparam int CTL_INC_DST = 18;
    localparam int CTL_SEL_SRC = 17;
    localparam int CTL_SEL_DST = 16;
    localparam int DESC_WORDS  = 4;
    localparam int WORD_BYTES  = 4;
    localparam int IDXW        = $clog2(DESC_WORDS);
    localparam int BSHIFT      = $clog2(WORD_BYTES);

    typedef struct packed {
        logic inc_src;
        logic inc_dst;
        logic sel_src;
        logic sel_dst;
    } chan_flags_t;
endpackage

// File: rtl/dcf_sequencer.sv
// Fetch sequencer: walks the four words of one descriptor with a
// request/valid handshake. Assumes the memory only answers while rd_req is high.
module dcf_sequencer
    import desc_chain_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   start_base,
    input  logic            rd_valid,
    output logic            busy,
    output logic [AW-1:0]   rd_addr,
    output logic [IDXW-1:0] word_idx,
    output logic            take,
    output logic            last_take,
    output logic [AW-1:0]   base
);
    logic            busy_q;
    logic [IDXW-1:0] idx_q;
    logic [AW-1:0]   base_q;

    // Acceptance of returned words and detection of the final one.
    always_comb begin
        take      = busy_q && rd_valid;
        last_take = take && (idx_q == IDXW'(DESC_WORDS - 1));
    end

    // State, word index and descriptor base register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            base_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                base_q <= start_base;
            end
        end else if (take) begin
            idx_q <= idx_q + 1'b1;
            if (last_take) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Word address within the descriptor.
    always_comb begin
        rd_addr  = base_q + (AW'(idx_q) << BSHIFT);
        busy     = busy_q;
        word_idx = idx_q;
        base     = base_q;
    end
endmodule

// File: rtl/dcf_stage.sv
// Staging buffer: holds the leading descriptor words until the last word
// arrives, so that the commit happens in one cycle.
module dcf_stage
    import desc_chain_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             take,
    input  logic [IDXW-1:0]                  word_idx,
    input  logic [DW-1:0]                    rd_data,
    output logic [DESC_WORDS-2:0][DW-1:0]    words
);
    localparam int HELD = DESC_WORDS - 1;

    logic [HELD-1:0][DW-1:0] slot_q;

    for (genvar w = 0; w < HELD; w++) begin : g_slot
        // Capture word w of the descriptor when it is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[w] <= '0;
            end else if (take && (word_idx == IDXW'(w))) begin
                slot_q[w] <= rd_data;
            end
        end
    end

    // Expose the held words.
    always_comb words = slot_q;
endmodule

// File: rtl/dcf_commit.sv
// Working configuration registers: loaded from the head strobe, the skip
// path or a completed fetch. Assumes head_set and skip arrive only while idle.
module dcf_commit
    import desc_chain_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int SZW = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          head_wr,
    input  logic [AW-1:0]                 head_ptr,
    input  logic                          skip,
    input  logic                          commit,
    input  logic [DESC_WORDS-2:0][DW-1:0] words,
    input  logic [DW-1:0]                 next_word,
    input  logic [AW-1:0]                 base,
    output chan_flags_t                   flags,
    output logic [SZW-1:0]                total_size,
    output logic [AW-1:0]                 src_addr,
    output logic [AW-1:0]                 dst_addr,
    output logic [AW-1:0]                 cur_desc,
    output logic [AW-1:0]                 desc_ptr,
    output logic                          more_follows,
    output logic                          load_done
);
    logic [DW-1:0] ctrl_w;
    chan_flags_t   flags_d;

    // Decode the control word fields.
    always_comb begin
        ctrl_w          = words[0];
        flags_d.inc_src = ctrl_w[CTL_INC_SRC];
        flags_d.inc_dst = ctrl_w[CTL_INC_DST];
        flags_d.sel_src = ctrl_w[CTL_SEL_SRC];
        flags_d.sel_dst = ctrl_w[CTL_SEL_DST];
    end

    // Descriptor-derived configuration, replaced only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags      <= '0;
            total_size <= '0;
            src_addr   <= '0;
            dst_addr   <= '0;
            cur_desc   <= '0;
        end else if (commit) begin
            flags      <= flags_d;
            total_size <= ctrl_w[SZW-1:0];
            src_addr   <= words[1][AW-1:0];
            dst_addr   <= words[2][AW-1:0];
            cur_desc   <= base;
        end
    end

    // Chain pointer: head strobe while idle, next word on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_ptr <= '0;
        end else if (commit) begin
            desc_ptr <= next_word[AW-1:0];
        end else if (head_wr) begin
            desc_ptr <= head_ptr;
        end
    end

    // Continuation flag and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            more_follows <= 1'b0;
            load_done    <= 1'b0;
        end else begin
            load_done <= commit || skip;
            if (commit) begin
                more_follows <= ~ctrl_w[CTL_EOL];
            end else if (skip) begin
                more_follows <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/desc_chain_fetch.sv
// Descriptor chain fetch unit for one DMA channel. It fetches a four-word
// descriptor on request and updates the channel configuration atomically.
// Assumes AW and SZW do not exceed the 32-bit word width.
module desc_chain_fetch
    import desc_chain_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SZW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_req,
    input  logic           use_desc,
    input  logic           head_set,
    input  logic [AW-1:0]  head_ptr,
    output logic           rd_req,
    output logic [AW-1:0]  rd_addr,
    input  logic           rd_valid,
    input  logic [31:0]    rd_data,
    output logic           inc_src,
    output logic           inc_dst,
    output logic           sel_src,
    output logic           sel_dst,
    output logic [SZW-1:0] total_size,
    output logic [AW-1:0]  src_addr,
    output logic [AW-1:0]  dst_addr,
    output logic [AW-1:0]  cur_desc,
    output logic [AW-1:0]  desc_ptr,
    output logic           more_follows,
    output logic           load_done
);
    localparam int DW = 32;

    logic                          busy;
    logic [IDXW-1:0]               word_idx;
    logic                          take;
    logic                          last_take;
    logic [AW-1:0]                 base;
    logic [DESC_WORDS-2:0][DW-1:0] words;
    logic                          start;
    logic                          skip;
    logic                          head_wr;
    logic [AW-1:0]                 start_base;
    chan_flags_t                   flags;

    // Request qualification: act only while idle; the new head wins the base.
    always_comb begin
        head_wr    = head_set && !busy;
        start      = load_req && use_desc && !busy;
        skip       = load_req && !use_desc && !busy;
        start_base = head_set ? head_ptr : desc_ptr;
        rd_req     = busy;
    end

    dcf_sequencer #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_base (start_base),
        .rd_valid   (rd_valid),
        .busy       (busy),
        .rd_addr    (rd_addr),
        .word_idx   (word_idx),
        .take       (take),
        .last_take  (last_take),
        .base       (base)
    );

    dcf_stage #(.DW(DW)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .word_idx (word_idx),
        .rd_data  (rd_data),
        .words    (words)
    );

    dcf_commit #(.AW(AW), .DW(DW), .SZW(SZW)) u_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .head_wr      (head_wr),
        .head_ptr     (head_ptr),
        .skip         (skip),
        .commit       (last_take),
        .words        (words),
        .next_word    (rd_data),
        .base         (base),
        .flags        (flags),
        .total_size   (total_size),
        .src_addr     (src_addr),
        .dst_addr     (dst_addr),
        .cur_desc     (cur_desc),
        .desc_ptr     (desc_ptr),
        .more_follows (more_follows),
        .load_done    (load_done)
    );

    // Flatten the flag struct onto the ports.
    always_comb begin
        inc_src = flags.inc_src;
        inc_dst = flags.inc_dst;
        sel_src = flags.sel_src;
        sel_dst = flags.sel_dst;
    end
endmodule

// File: rtl/desc_chain_fetch_chk.sv
// Protocol and ordering checks for the descriptor chain fetch unit,
// attached through a bind statement.
module desc_chain_fetch_chk #(
    parameter int AW  = 32,
    parameter int SZW = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           load_req,
    input logic           use_desc,
    input logic           head_set,
    input logic           rd_req,
    input logic [AW-1:0]  rd_addr,
    input logic           rd_valid,
    input logic [SZW-1:0] total_size,
    input logic [AW-1:0]  src_addr,
    input logic [AW-1:0]  dst_addr,
    input logic [AW-1:0]  cur_desc,
    input logic [AW-1:0]  desc_ptr,
    input logic           more_follows,
    input logic           load_done
);
    // R2: the address is held while a read waits for its data.
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    // R2: after an accepted word the next read is one word further on.
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid) |=> (!rd_req || (rd_addr == $past(rd_addr) + AW'(4))));

    // R7: configuration outputs move only in the completion cycle.
    p_atomic_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> ($stable(src_addr) && $stable(dst_addr)
                        && $stable(total_size) && $stable(cur_desc)));

    // R7: completion is reported only once the reads have stopped.
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !rd_req);

    // R8: a load without descriptors clears the flag and completes at once.
    p_skip_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !use_desc && !rd_req) |=> (!more_follows && load_done && !rd_req));

    // R10: a head strobe during a fetch leaves the pointer alone.
    p_head_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && head_set) |=> ((desc_ptr == $past(desc_ptr)) || load_done));

    // R11: without a request, a valid pulse starts nothing.
    p_stray_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && rd_valid && !load_req) |=> !rd_req);
endmodule

bind desc_chain_fetch desc_chain_fetch_chk #(.AW(AW), .SZW(SZW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_req     (load_req),
    .use_desc     (use_desc),
    .head_set     (head_set),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .rd_valid     (rd_valid),
    .total_size   (total_size),
    .src_addr     (src_addr),
    .dst_addr     (dst_addr),
    .cur_desc     (cur_desc),
    .desc_ptr     (desc_ptr),
    .more_follows (more_follows),
    .load_done    (load_done)
);

// File: tb/desc_chain_fetch_test.sv
`timescale 1ns/1ps
module desc_chain_fetch_test;
    localparam int AW  = 32;
    localparam int SZW = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           load_req = 1'b0;
    logic           use_desc = 1'b1;
    logic           head_set = 1'b0;
    logic [AW-1:0]  head_ptr = '0;
    logic           rd_req;
    logic [AW-1:0]  rd_addr;
    logic           rd_valid = 1'b0;
    logic [31:0]    rd_data = '0;
    logic           inc_src, inc_dst, sel_src, sel_dst;
    logic [SZW-1:0] total_size;
    logic [AW-1:0]  src_addr, dst_addr, cur_desc, desc_ptr;
    logic           more_follows, load_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    desc_chain_fetch #(.AW(AW), .SZW(SZW)) uut (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .use_desc(use_desc),
        .head_set(head_set), .head_ptr(head_ptr), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .inc_src(inc_src), .inc_dst(inc_dst), .sel_src(sel_src), .sel_dst(sel_dst),
        .total_size(total_size), .src_addr(src_addr), .dst_addr(dst_addr),
        .cur_desc(cur_desc), .desc_ptr(desc_ptr), .more_follows(more_follows),
        .load_done(load_done)
    );

    // ---------------- memory image and responder ----------------
    logic [31:0] mem [int unsigned];
    int  lat = 0;
    bit  spur_en = 0;

    function automatic logic [31:0] memrd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'h5A5A_0000;
    endfunction

    task automatic put_desc(input logic [31:0] b, input logic [31:0] c,
                            input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] n);
        mem[b] = c; mem[b + 4] = s; mem[b + 8] = d; mem[b + 12] = n;
    endtask

    initial begin
        int cnt = 0;
        bit tog = 0;
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                rd_valid = 1'b0;
                cnt = 0;
            end else if (rd_req) begin
                if (cnt >= lat) begin
                    rd_valid = 1'b1;
                    rd_data  = memrd(rd_addr);
                    cnt = 0;
                end else begin
                    cnt++;
                end
            end else if (spur_en) begin
                tog = !tog;
                if (tog) begin
                    rd_valid = 1'b1;
                    rd_data  = 32'hDEAD_BEEF;
                end
            end
        end
    end

    // ---------------- behavioural reference model ----------------
    bit          m_busy, m_done, m_more;
    int          m_idx;
    logic [31:0] m_base, m_ptr, m_cur, m_src, m_dst;
    logic [3:0]  m_flags;
    logic [11:0] m_size;
    logic [31:0] wq[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_more = 0; m_idx = 0;
            m_base = 0; m_ptr = 0; m_cur = 0; m_src = 0; m_dst = 0;
            m_flags = 0; m_size = 0; wq.delete();
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (rd_valid) begin
                    wq.push_back(rd_data);
                    m_idx++;
                    if (m_idx == 4) begin
                        m_flags = {wq[0][19], wq[0][18], wq[0][17], wq[0][16]};
                        m_size  = wq[0][11:0];
                        m_src   = wq[1];
                        m_dst   = wq[2];
                        m_cur   = m_base;
                        m_ptr   = wq[3];
                        m_more  = !wq[0][20];
                        m_busy  = 0;
                        m_done  = 1;
                    end
                end
            end else begin
                if (head_set) m_ptr = head_ptr;
                if (load_req) begin
                    if (use_desc) begin
                        m_base = m_ptr; m_busy = 1; m_idx = 0; wq.delete();
                    end else begin
                        m_more = 0; m_done = 1;
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    int dut_dones = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 rd_req", {31'b0, rd_req}, {31'b0, m_busy});
            if (m_busy) chk("R2 rd_addr", rd_addr, m_base + 32'(4 * m_idx));
            chk("R3 flags", {28'b0, inc_src, inc_dst, sel_src, sel_dst}, {28'b0, m_flags});
            chk("R3 total_size", {20'b0, total_size}, {20'b0, m_size});
            chk("R4 src_addr", src_addr, m_src);
            chk("R4 dst_addr", dst_addr, m_dst);
            chk("R5 cur_desc", cur_desc, m_cur);
            chk("R5 desc_ptr", desc_ptr, m_ptr);
            chk("R6 more_follows", {31'b0, more_follows}, {31'b0, m_more});
            chk("R7 load_done", {31'b0, load_done}, {31'b0, m_done});
            if (load_done) dut_dones++;
        end
    end

    task automatic wait_done(input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!load_done && n < 300);
        chk({tag, " completion seen"}, {31'b0, load_done}, 32'd1);
    endtask

    task automatic one_load;
        @(negedge clk) load_req = 1'b1;
        @(negedge clk) load_req = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int d0;
        put_desc(32'h100, 32'h000A_0123, 32'h1000_0000, 32'h2000_0040, 32'h200);
        put_desc(32'h200, 32'h0015_0FFF, 32'h3000_0004, 32'h4000_0008, 32'h300);
        put_desc(32'h300, 32'h000F_0007, 32'hAAAA_0000, 32'h5555_0000, 32'h100);

        // R1: reset state.
        repeat (3) @(negedge clk);
        chk("R1 rd_req", {31'b0, rd_req}, 0);
        chk("R1 desc_ptr", desc_ptr, 0);
        chk("R1 more_follows", {31'b0, more_follows}, 0);
        chk("R1 load_done", {31'b0, load_done}, 0);
        rst_n = 1'b1;

        // R10: head pointer while idle.
        @(negedge clk) begin head_set = 1'b1; head_ptr = 32'h100; end
        @(negedge clk) head_set = 1'b0;
        chk("R10 head loaded", desc_ptr, 32'h100);

        // R2..R6: fetch descriptor at 0x100 with zero latency.
        one_load();
        wait_done("R2");
        chk("R3 inc_src", {31'b0, inc_src}, 1);
        chk("R3 sel_dst", {31'b0, sel_dst}, 0);
        chk("R3 size", {20'b0, total_size}, 32'h123);
        chk("R4 src", src_addr, 32'h1000_0000);
        chk("R4 dst", dst_addr, 32'h2000_0040);
        chk("R5 cur", cur_desc, 32'h100);
        chk("R5 next", desc_ptr, 32'h200);
        chk("R6 more set", {31'b0, more_follows}, 1);

        // R8: load without descriptors.
        @(negedge clk) begin use_desc = 1'b0; load_req = 1'b1; end
        @(negedge clk) begin load_req = 1'b0; use_desc = 1'b1; end
        chk("R8 done pulse", {31'b0, load_done}, 1);
        chk("R8 more cleared", {31'b0, more_follows}, 0);
        chk("R8 src kept", src_addr, 32'h1000_0000);
        chk("R8 no read", {31'b0, rd_req}, 0);

        // R9, R10, R11: slow memory, stray valids, requests while busy.
        lat = 3; spur_en = 1;
        repeat (4) @(negedge clk);
        d0 = dut_dones;
        one_load();
        repeat (3) @(negedge clk);
        load_req = 1'b1; head_set = 1'b1; head_ptr = 32'h700;
        @(negedge clk) begin load_req = 1'b0; head_set = 1'b0; end
        wait_done("R11");
        repeat (20) @(negedge clk);
        chk("R9 single completion", dut_dones - d0, 1);
        chk("R10 busy head ignored", desc_ptr, 32'h300);
        chk("R11 cur", cur_desc, 32'h200);
        chk("R11 size max", {20'b0, total_size}, 32'hFFF);
        chk("R6 end of list", {31'b0, more_follows}, 0);
        spur_en = 0;

        // R10: head strobe and load in the same cycle.
        @(negedge clk) begin head_set = 1'b1; head_ptr = 32'h100; load_req = 1'b1; end
        @(negedge clk) begin head_set = 1'b0; load_req = 1'b0; end
        wait_done("R10");
        chk("R10 same-cycle base", cur_desc, 32'h100);

        // R7: load held through completion starts the next fetch at once.
        lat = 1;
        d0 = dut_dones;
        @(negedge clk) load_req = 1'b1;
        wait_done("R7 first");
        wait_done("R7 second");
        load_req = 1'b0;
        chk("R7 back-to-back count", dut_dones - d0, 2);
        chk("R7 chained cur", cur_desc, 32'h300);
        chk("R7 chained next", desc_ptr, 32'h100);
        chk("R3 all flags", {28'b0, inc_src, inc_dst, sel_src, sel_dst}, 32'hF);
        repeat (5) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule